// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block turns simple memory requests into SDRAM command-pin patterns. A requester presents an operation (open a row, read, write, or close a bank), a bank number, an address and an auto-close flag. The block drives the chip-select, row strobe, column strobe and write-enable pins, the bank pins and the address pins, all from registers. It keeps an open/idle record for each of four banks, plus a row-to-column delay timer and an auto-close timer for each bank.

A request waits on a ready/valid handshake until its timing allows it. A request that breaks the bank state rules is taken but puts no command on the pins. Instead it raises a one-cycle error pulse. Burst length and CAS latency come from a small mode store written through a configuration strobe. These values set the auto-close time. Refresh, power-up sequencing and the data path belong to other blocks.

Top module: `sdram_cmd_gen`

## Requirements
- R1: An accepted open-row request (`req_op`=0) drives CS#/RAS# low and CAS#/WE# high on the cycle after acceptance. The bank pins carry `req_bank` and all 12 address pins carry the row. The bank reads open (`bank_open` bit set) from that same cycle.
- R2: An accepted read (`req_op`=1) drives CS#/CAS# low and RAS#/WE# high. An accepted write (`req_op`=2) drives CS#/CAS#/WE# low and RAS# high. For both, A8..A0 carry the column taken from `req_addr[8:0]`, A10 carries `req_ap`, and A9 and A11 are zero. The command appears one cycle after acceptance.
- R3: An accepted close request (`req_op`=3) drives CS#/RAS#/WE# low and CAS# high, with A10 low and the bank on the bank pins. The bank reads idle from the next cycle. Closing an idle bank is legal.
- R4: In any cycle where no command is issued, all four strobes are high and the bank and address pins are zero.
- R5: A read or write to an open bank stalls (`req_ready` low) until T_RCD cycles have passed since that bank's open-row request was accepted. It is accepted when the current cycle is at least the acceptance cycle plus T_RCD.
- R6: A read or write with `req_ap` high closes its bank automatically. The bank reads idle N cycles after the command shows on the pins. N is the burst length for a write and the burst length plus CAS latency for a read. Any request to that bank stalls until the bank has closed.
- R7: A read or write to an idle bank, or an open-row request to an open bank, is accepted but issues no command. It raises `req_err` for one cycle (one cycle after acceptance) and leaves `bank_open` unchanged.
- R8: With full-page bursts selected, a read or write with `req_ap` high is rejected in the same way as R7. Without `req_ap` it issues normally and never auto-closes.
- R9: A high `cfg_wr` captures `cfg_burst` and `cfg_cl` (CAS latency 1 to 3), and the new values take effect from the next cycle. Burst codes: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page, and 4 to 6 give 1. After reset the burst length is 1 and the CAS latency is 2.
- R10: After reset the pins show no command, all banks are idle and `req_err` is low.
- R11: `req_ready` is low only when `req_valid` is high and the request stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Mode store write strobe |
| cfg_burst | input | 3 | Burst length code |
| cfg_cl | input | 2 | CAS latency |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 open row, 1 read, 2 write, 3 close bank |
| req_bank | input | 2 | Target bank |
| req_addr | input | 12 | Row, or column in bits 8..0 |
| req_ap | input | 1 | Auto-close after burst |
| req_ready | output | 1 | Request taken this cycle |
| req_err | output | 1 | Previous taken request was illegal |
| bank_open | output | 4 | Per-bank open-row flags |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank pins |
| sd_a | output | 12 | Address pins |

## Verification
The bench uses the default parameters: four banks, a 12-bit row, a 9-bit column and T_RCD of 3. With T_RCD of 3, a read that follows its open-row request at once stalls for two cycles, so the stall edge is visible. The bench switches between several burst and latency settings, including burst 8 with latency 3 (an 11-cycle auto-close) and full page. This covers the shortest and longest auto-close times, as well as the full-page rejection. The bench also interleaves the four banks, so the per-bank timers are seen running side by side.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_PRE = 2'd3
  } req_op_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobes_t;

  localparam strobes_t STB_NOP = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam strobes_t STB_ACT = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
  localparam strobes_t STB_RD  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
  localparam strobes_t STB_WR  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
  localparam strobes_t STB_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
endpackage

// File: rtl/sdram_mode_store.sv
module sdram_mode_store #(
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_burst,
  input  logic [1:0]      cfg_cl,
  output logic [BL_W-1:0] burst_len,
  output logic            full_page,
  output logic [1:0]      cas_lat
);
  logic [2:0] code_q, code_d;
  logic [1:0] cl_q, cl_d;

  always_comb begin
    code_d = code_q;
    cl_d   = cl_q;
    if (cfg_wr) begin
      code_d = cfg_burst;
      cl_d   = cfg_cl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 3'd0;
      cl_q   <= 2'd2;
    end else begin
      code_q <= code_d;
      cl_q   <= cl_d;
    end
  end

  always_comb begin
    full_page = (code_q == 3'd7);
    unique case (code_q)
      3'd1:    burst_len = BL_W'(2);
      3'd2:    burst_len = BL_W'(4);
      3'd3:    burst_len = BL_W'(8);
      default: burst_len = BL_W'(1);
    endcase
  end

  assign cas_lat = cl_q;

  AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cas_lat == $past(cfg_cl))) else $error("mode capture"); // R9
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int NB    = 4,
  parameter int T_RCD = 3,
  parameter int AP_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB-1:0]   act_fire,
  input  logic [NB-1:0]   pre_fire,
  input  logic [NB-1:0]   ap_start,
  input  logic [AP_W-1:0] ap_len,
  output logic [NB-1:0]   open_q,
  output logic [NB-1:0]   rcd_ok,
  output logic [NB-1:0]   ap_busy
);
  localparam int CNT_W = (T_RCD > 1) ? $clog2(T_RCD + 1) : 1;
  localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(T_RCD - 1);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic             open_d;
    logic [CNT_W-1:0] rcd_q, rcd_d;
    logic [AP_W-1:0]  ap_q, ap_d;
    logic             ap_last;

    assign ap_last = (ap_q == AP_W'(1));

    always_comb begin
      rcd_d = rcd_q;
      if (act_fire[g])          rcd_d = RCD_LOAD;
      else if (rcd_q != '0)     rcd_d = rcd_q - CNT_W'(1);

      ap_d = ap_q;
      if (ap_start[g])          ap_d = ap_len;
      else if (ap_q != '0)      ap_d = ap_q - AP_W'(1);

      open_d = open_q[g];
      if (act_fire[g])                   open_d = 1'b1;
      else if (pre_fire[g] || ap_last)   open_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[g] <= 1'b0;
        rcd_q     <= '0;
        ap_q      <= '0;
      end else begin
        open_q[g] <= open_d;
        rcd_q     <= rcd_d;
        ap_q      <= ap_d;
      end
    end

    assign rcd_ok[g]  = (rcd_q == '0);
    assign ap_busy[g] = (ap_q != '0);

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      act_fire[g] |=> open_q[g]) else $error("open"); // R1
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      pre_fire[g] |=> !open_q[g]) else $error("close"); // R3
    AST_AP_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      ap_busy[g] |-> open_q[g]) else $error("ap idle"); // R6
    if (T_RCD > 1) begin : g_rcd_chk
      AST_RCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire[g] |=> !rcd_ok[g]) else $error("rcd"); // R5
    end
  end
endmodule

// File: rtl/sdram_pin_encoder.sv
module sdram_pin_encoder
  import sdram_cmd_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  req_op_e          op,
  input  logic [BA_W-1:0]  bank,
  input  logic [ROW_W-1:0] addr,
  input  logic             ap,
  output strobes_t         stb_q,
  output logic [BA_W-1:0]  ba_q,
  output logic [ROW_W-1:0] a_q
);
  strobes_t         stb_d;
  logic [BA_W-1:0]  ba_d;
  logic [ROW_W-1:0] a_d;
  logic [ROW_W-1:0] col_word;

  always_comb begin
    col_word              = '0;
    col_word[COL_W-1:0]   = addr[COL_W-1:0];
    col_word[AP_BIT]      = ap;
    stb_d = STB_NOP;
    ba_d  = '0;
    a_d   = '0;
    if (issue) begin
      ba_d = bank;
      unique case (op)
        OP_ACT: begin stb_d = STB_ACT; a_d = addr;     end
        OP_RD:  begin stb_d = STB_RD;  a_d = col_word; end
        OP_WR:  begin stb_d = STB_WR;  a_d = col_word; end
        default: stb_d = STB_PRE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= STB_NOP;
      ba_q  <= '0;
      a_q   <= '0;
    end else begin
      stb_q <= stb_d;
      ba_q  <= ba_d;
      a_q   <= a_d;
    end
  end

  AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (stb_q == STB_NOP && a_q == '0)) else $error("nop"); // R4
  AST_AP_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (op == OP_RD || op == OP_WR)) |=> (a_q[AP_BIT] == $past(ap))) else $error("ap pin"); // R2
endmodule

// File: rtl/sdram_cmd_gen.sv
module sdram_cmd_gen
  import sdram_cmd_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10,
  parameter int T_RCD  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [2:0]             cfg_burst,
  input  logic [1:0]             cfg_cl,
  input  logic                   req_valid,
  input  logic [1:0]             req_op,
  input  logic [$clog2(NB)-1:0]  req_bank,
  input  logic [ROW_W-1:0]       req_addr,
  input  logic                   req_ap,
  output logic                   req_ready,
  output logic                   req_err,
  output logic [NB-1:0]          bank_open,
  output logic                   sd_cs_n,
  output logic                   sd_ras_n,
  output logic                   sd_cas_n,
  output logic                   sd_we_n,
  output logic [$clog2(NB)-1:0]  sd_ba,
  output logic [ROW_W-1:0]       sd_a
);
  localparam int BA_W = $clog2(NB);
  localparam int BL_W = 4;
  localparam int AP_W = BL_W + 1;

  logic [BL_W-1:0] burst_len;
  logic            full_page;
  logic [1:0]      cas_lat;
  logic [NB-1:0]   rcd_ok, ap_busy;
  logic [NB-1:0]   act_fire, pre_fire, ap_start;
  logic [AP_W-1:0] ap_len;
  req_op_e         op;
  logic            is_rdwr, sel_open, bad, stall, take, issue;
  logic            err_d;
  strobes_t        stb;

  sdram_mode_store #(.BL_W(BL_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_burst(cfg_burst), .cfg_cl(cfg_cl),
    .burst_len(burst_len), .full_page(full_page), .cas_lat(cas_lat)
  );

  sdram_bank_tracker #(.NB(NB), .T_RCD(T_RCD), .AP_W(AP_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .act_fire(act_fire), .pre_fire(pre_fire),
    .ap_start(ap_start), .ap_len(ap_len), .open_q(bank_open), .rcd_ok(rcd_ok),
    .ap_busy(ap_busy)
  );

  always_comb begin
    op       = req_op_e'(req_op);
    is_rdwr  = (op == OP_RD) || (op == OP_WR);
    sel_open = bank_open[req_bank];
    bad      = !ap_busy[req_bank] &&
               ((is_rdwr && !sel_open) || (op == OP_ACT && sel_open) ||
                (is_rdwr && req_ap && full_page));
    stall    = ap_busy[req_bank] || (is_rdwr && sel_open && !bad && !rcd_ok[req_bank]);
    take     = req_valid && !stall;
    issue    = take && !bad;
    err_d    = take && bad;
    ap_len   = AP_W'(burst_len) + ((op == OP_RD) ? AP_W'(cas_lat) : AP_W'(0));
    act_fire = '0;
    pre_fire = '0;
    ap_start = '0;
    act_fire[req_bank] = issue && (op == OP_ACT);
    pre_fire[req_bank] = issue && (op == OP_PRE);
    ap_start[req_bank] = issue && is_rdwr && req_ap;
  end

  assign req_ready = !(req_valid && stall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_err <= 1'b0;
    else        req_err <= err_d;
  end

  sdram_pin_encoder #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_pins (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .bank(req_bank),
    .addr(req_addr), .ap(req_ap), .stb_q(stb), .ba_q(sd_ba), .a_q(sd_a)
  );

  assign sd_cs_n  = stb.cs_n;
  assign sd_ras_n = stb.ras_n;
  assign sd_cas_n = stb.cas_n;
  assign sd_we_n  = stb.we_n;

  AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> sd_cs_n) else $error("err cmd"); // R7
  AST_ERR_KEEPS_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (bank_open == $past(bank_open))) else $error("err state"); // R7
  AST_FULLPAGE_AP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_rdwr && req_ap && full_page && sel_open && !ap_busy[req_bank]) |=> req_err)
    else $error("full page ap"); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> req_ready) else $error("ready"); // R11
endmodule

// File: tb/tb_sdram_cmd_gen.sv
module tb_sdram_cmd_gen;
  localparam int T_RCD = 3;

  logic        clk, rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_burst;
  logic [1:0]  cfg_cl;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [1:0]  req_bank;
  logic [11:0] req_addr;
  logic        req_ap;
  logic        req_ready, req_err;
  logic [3:0]  bank_open;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;

  int checks = 0;
  int failures = 0;

  sdram_cmd_gen #(.T_RCD(T_RCD)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_burst(cfg_burst), .cfg_cl(cfg_cl),
    .req_valid(req_valid), .req_op(req_op), .req_bank(req_bank), .req_addr(req_addr),
    .req_ap(req_ap), .req_ready(req_ready), .req_err(req_err), .bank_open(bank_open),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model state
  int  cyc = 0;
  bit  mopen [4];
  int  act_cyc [4];
  int  close_cyc [4];
  int  mbl = 1;
  int  mcl = 2;
  bit  mfull = 0;
  logic [3:0]  exp_stb = 4'b1111;
  logic [1:0]  exp_ba = '0;
  logic [11:0] exp_a = '0;
  bit          exp_err = 0;
  string       exp_tag = "R10";
  bit          last_ready;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] op, input int b,
                      input logic [11:0] addr, input bit ap);
    bit busy, rdwr, bad, stall, take;
    logic [3:0] mvec;
    string rtag;
    @(negedge clk);
    cfg_wr = 1'b0;
    for (int k = 0; k < 4; k++)
      if (close_cyc[k] == cyc) begin mopen[k] = 0; close_cyc[k] = -1; end
    for (int k = 0; k < 4; k++) mvec[k] = mopen[k];
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == exp_stb, exp_tag, "strobes",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, exp_stb);
    chk(sd_ba == exp_ba && sd_a == exp_a, exp_tag, "ba/addr", {sd_ba, sd_a}, {exp_ba, exp_a});
    chk(req_err == exp_err, "R7", "req_err", req_err, exp_err);
    chk(bank_open == mvec, (close_cyc[0] == -1) ? "R3" : "R6", "bank_open", bank_open, mvec);
    req_valid = v; req_op = op; req_bank = 2'(b); req_addr = addr; req_ap = ap;
    #1;
    busy  = (close_cyc[b] != -1);
    rdwr  = (op == 2'd1 || op == 2'd2);
    bad   = !busy && ((rdwr && !mopen[b]) || (op == 2'd0 && mopen[b]) || (rdwr && ap && mfull));
    stall = busy || (rdwr && mopen[b] && !bad && cyc < act_cyc[b] + T_RCD);
    rtag  = busy ? "R6" : (stall ? "R5" : "R11");
    chk(req_ready == !(v && stall), rtag, "req_ready", req_ready, !(v && stall));
    take = v && !stall;
    last_ready = take;
    exp_err = take && bad;
    exp_stb = 4'b1111; exp_ba = '0; exp_a = '0;
    exp_tag = bad && take ? "R7" : "R4";
    if (take && !bad) begin
      exp_ba = 2'(b);
      case (op)
        2'd0: begin exp_stb = 4'b0011; exp_a = addr; exp_tag = "R1";
                    mopen[b] = 1; act_cyc[b] = cyc; end
        2'd3: begin exp_stb = 4'b0010; exp_tag = "R3"; mopen[b] = 0; end
        default: begin
          exp_stb = (op == 2'd1) ? 4'b0101 : 4'b0100;
          exp_a = '0; exp_a[8:0] = addr[8:0]; exp_a[10] = ap;
          exp_tag = "R2";
          if (ap) close_cyc[b] = cyc + 1 + mbl + ((op == 2'd1) ? mcl : 0);
        end
      endcase
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, 0, 12'h0, 0);
  endtask

  task automatic send(input logic [1:0] op, input int b, input logic [11:0] addr, input bit ap);
    for (int i = 0; i < 40; i++) begin
      step(1, op, b, addr, ap);
      if (last_ready) break;
    end
  endtask

  // R9: mode store write, model updated for requests from the next cycle on
  task automatic set_mode(input logic [2:0] code, input int cl);
    cfg_wr = 1'b1; cfg_burst = code; cfg_cl = 2'(cl);
    mfull = (code == 3'd7);
    case (code)
      3'd1: mbl = 2;
      3'd2: mbl = 4;
      3'd3: mbl = 8;
      default: mbl = 1;
    endcase
    mcl = cl;
    step(0, 2'd0, 0, 12'h0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin mopen[k] = 0; act_cyc[k] = -100; close_cyc[k] = -1; end
    rst_n = 0; cfg_wr = 0; cfg_burst = 0; cfg_cl = 2;
    req_valid = 0; req_op = 0; req_bank = 0; req_addr = 0; req_ap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2); // R10 reset state, R9 default BL1 CL2

    // R9 default mode: write auto-close after 1 cycle (R6)
    send(2'd0, 0, 12'h5A5, 0);      // R1
    send(2'd2, 0, 12'h1FF, 1);      // R5 stall then R2, R6
    send(2'd0, 0, 12'h123, 0);      // stalls while closing (R6)
    idle(4);

    set_mode(3'd2, 2);              // BL4 CL2
    send(2'd1, 0, 12'hE34, 0);      // R2 read, no auto-close
    send(2'd1, 0, 12'h011, 1);      // R6 close after 6
    idle(8);
    send(2'd1, 0, 12'h001, 0);      // R7 read to idle bank
    idle(1);

    // interleave banks
    send(2'd0, 1, 12'hABC, 0);
    send(2'd0, 2, 12'h0F0, 0);
    send(2'd0, 3, 12'hFFF, 0);
    send(2'd0, 1, 12'h111, 0);      // R7 open already open
    send(2'd2, 1, 12'h155, 1);      // R6 write close after 4
    send(2'd1, 2, 12'h0AA, 0);
    send(2'd3, 3, 12'h000, 0);      // R3
    send(2'd3, 3, 12'h000, 0);      // R3 close idle bank
    send(2'd2, 1, 12'h000, 0);      // stalls, then idle bank error
    idle(6);

    set_mode(3'd3, 3);              // BL8 CL3
    send(2'd0, 0, 12'h321, 0);
    send(2'd1, 0, 12'h0C3, 1);      // R6 close after 11
    send(2'd3, 0, 12'h000, 0);      // stalls until closed
    idle(3);

    set_mode(3'd7, 1);              // R9 full page
    send(2'd1, 2, 12'h002, 1);      // R8 rejected
    send(2'd2, 2, 12'h003, 0);      // R8 legal without auto-close
    idle(15);
    set_mode(3'd5, 1);              // R9 reserved code gives burst 1
    send(2'd1, 2, 12'h004, 1);      // close after 2
    idle(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule